// File: doc/BRIEF.md
# Buffered 16-bit Timer with Trigger Reset

This block is a 16-bit up-counter sitting behind an 8-bit register bus. Software programs it with four byte-wide registers: the counter low byte, the counter high byte (or its shadow), a control register and a status register. The counter advances on ticks taken either from the system clock or from an external clock strobe. The strobe is synchronised and edge-detected inside the block. A power-of-two prescaler divides the ticks before they reach the counter.

In buffered mode the high-byte address never touches the live high byte. It reaches a shadow byte instead. Reading the low byte latches the live high byte into the shadow. Writing the low byte commits the shadow into the live high byte on the same edge. Software can therefore read or load all 16 bits without tearing when the low byte rolls over between accesses.

A wrap from 0xFFFF to 0x0000 sets a sticky overflow flag, and that flag can raise an interrupt. A compare-match trigger input clears the count. The bus is a simple single-cycle register port with a combinational read path. It has no stream traffic and applies no back-pressure: every access completes in the cycle it is presented.

Top module: `buf_timer16`

## Requirements
- R1: Register map: address 0 is the low byte and address 1 is the high byte. Address 2 is control, with bit 0 run, bit 1 source (1 = external strobe), bits 3:2 prescale select and bit 7 buffered mode. Address 3 is status, with bit 0 the overflow flag and bit 1 the interrupt enable. With buffered mode on, address 1 reads and writes only the shadow byte and never the live high byte.
- R2: With buffered mode on, a read of address 0 copies the live high byte into the shadow on that access, so a later read of address 1 returns the high byte that belonged to that low byte.
- R3: With buffered mode on, a write of address 0 loads the low byte from the bus and the high byte from the shadow on the same clock edge.
- R4: With buffered mode off, address 1 reads and writes the live high byte, and address 0 reads and writes the live low byte.
- R5: The count increments by one per prescaled tick and wraps from 0xFFFF to 0x0000. The wrap sets the overflow flag, which stays set until software writes 0 to status bit 0.
- R6: The irq output is high exactly when both the overflow flag and the interrupt enable are 1.
- R7: Prescale select 0, 1, 2 and 3 advance the count once every 1, 2, 4 and 8 source ticks respectively.
- R8: Every write to address 0 clears the prescaler. Writes to address 1 leave it unchanged.
- R9: A trig_clr pulse clears the count to 0x0000 and leaves the overflow flag unchanged.
- R10: A bus write that loads the counter in the same cycle as trig_clr takes effect, and the trigger is ignored.
- R11: With source = 1, each rising edge of ext_clk yields one source tick after a two-flop synchroniser. With run = 0, the count never advances.
- R12: After reset, all four registers read 0x00 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ext_clk | input | 1 | External clock strobe, asynchronous |
| trig_clr | input | 1 | Compare-match trigger that clears the count |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two things can land on the counter in the same cycle: a bus load and a trigger clear. The bench preloads the high byte with a non-zero value. It then raises trig_clr for exactly the cycle of a low-byte write. The counter must read back the written low byte alongside the old high byte, not 0x0000. A second collision happens between a low-byte read and an advancing counter in buffered mode. A rollover from 0x12FF is provoked after the latch, and the shadow must still hold 0x12.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_SRC   = 1;
  localparam int CB_PS_LO = 2;
  localparam int CB_BUF   = 7;

  // status register bit positions
  localparam int SB_FLAG = 0;
  localparam int SB_IE   = 1;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PS_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_ext,
  input  logic [PS_W-1:0] ps,
  input  logic            pre_clr,
  input  logic            ext_clk,
  output logic            tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_rise;
  logic              src_tick;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  mask;

  // synchroniser chain, stage 0 samples the asynchronous pin
  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          sync_q[g] <= 1'b0;
        else if (g == 0)
          sync_q[g] <= ext_clk;
        else
          sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_N-1];
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~prev_q;
  assign src_tick = run & (src_ext ? ext_rise : 1'b1);

  always_comb begin
    for (int i = 0; i < PRE_W; i++)
      mask[i] = (i < int'(ps));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (pre_clr)  pre_q <= '0;
    else if (src_tick) pre_q <= pre_q + 1'b1;
  end

  assign tick = src_tick & ((pre_q & mask) == mask);

  // R8
  pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> (pre_q == '0));

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pre_clr) |=> (pre_q == $past(pre_q)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [DW-1:0]   lo_val,
  input  logic [W-DW-1:0] hi_val,
  input  logic            trig,
  input  logic            tick,
  output logic [W-1:0]    cnt,
  output logic            wrap
);
  logic any_ld;
  assign any_ld = ld_lo | ld_hi;
  assign wrap   = tick & ~any_ld & ~trig & (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (any_ld) begin
      if (ld_lo) cnt[DW-1:0] <= lo_val;
      if (ld_hi) cnt[W-1:DW] <= hi_val;
    end else if (trig) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (cnt[DW-1:0] == $past(lo_val)));

  // R9
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ld_lo && !ld_hi) |=> (cnt == '0));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/buf_timer16.sv
module buf_timer16 #(
  parameter int DW     = 8,
  parameter int PS_W   = 2,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_clk,
  input  logic          trig_clr,
  output logic          irq
);
  import tmr_pkg::*;
  localparam int CW = 2 * DW;

  logic            buf_en, src_ext, run;
  logic [PS_W-1:0] ps;
  logic [DW-1:0]   shadow;
  logic            flag, ie;
  logic [CW-1:0]   cnt;
  logic            tick, wrap;
  logic            wr_lo, wr_hi, wr_ctrl, wr_st, rd_lo;
  logic            ld_hi;
  logic [DW-1:0]   hi_val;
  logic [DW-1:0]   ctrl_rb, stat_rb;

  assign wr_lo   = bus_wr && (bus_addr == REG_LO);
  assign wr_hi   = bus_wr && (bus_addr == REG_HI);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_st   = bus_wr && (bus_addr == REG_STAT);
  assign rd_lo   = bus_rd && (bus_addr == REG_LO);

  assign ld_hi  = buf_en ? wr_lo : wr_hi;
  assign hi_val = buf_en ? shadow : bus_wdata;

  tmr_tick_gen #(.PS_W(PS_W), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .src_ext(src_ext), .ps(ps),
    .pre_clr(wr_lo), .ext_clk(ext_clk), .tick(tick)
  );

  tmr_counter #(.W(CW), .DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld_lo(wr_lo), .ld_hi(ld_hi),
    .lo_val(bus_wdata), .hi_val(hi_val), .trig(trig_clr), .tick(tick),
    .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en  <= 1'b0;
      src_ext <= 1'b0;
      run     <= 1'b0;
      ps      <= '0;
    end else if (wr_ctrl) begin
      buf_en  <= bus_wdata[CB_BUF];
      src_ext <= bus_wdata[CB_SRC];
      run     <= bus_wdata[CB_RUN];
      ps      <= bus_wdata[CB_PS_LO +: PS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shadow <= '0;
    else if (buf_en && wr_hi)  shadow <= bus_wdata;
    else if (buf_en && rd_lo)  shadow <= cnt[CW-1:DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ie   <= 1'b0;
    end else begin
      if (wrap)       flag <= 1'b1;
      else if (wr_st) flag <= bus_wdata[SB_FLAG];
      if (wr_st)      ie   <= bus_wdata[SB_IE];
    end
  end

  always_comb begin
    ctrl_rb = '0;
    ctrl_rb[CB_BUF]             = buf_en;
    ctrl_rb[CB_SRC]             = src_ext;
    ctrl_rb[CB_RUN]             = run;
    ctrl_rb[CB_PS_LO +: PS_W]   = ps;
    stat_rb = '0;
    stat_rb[SB_FLAG]            = flag;
    stat_rb[SB_IE]              = ie;
  end

  always_comb begin
    unique case (bus_addr)
      REG_LO:   bus_rdata = cnt[DW-1:0];
      REG_HI:   bus_rdata = buf_en ? shadow : cnt[CW-1:DW];
      REG_CTRL: bus_rdata = ctrl_rb;
      default:  bus_rdata = stat_rb;
    endcase
  end

  assign irq = flag & ie;

  // R2
  shadow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && rd_lo) |=> (shadow == $past(cnt[CW-1:DW])));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_st) |=> flag);

  // R1
  hi_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && wr_hi && !tick && !trig_clr) |=> (cnt == $past(cnt)));
endmodule

// File: tb/sim_buf_timer16.sv
module sim_buf_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       trig_clr = 1'b0;
  logic       irq;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buf_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .trig_clr(trig_clr), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R12 reg after reset", v, 8'h00);
    end
    check("R12 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_direct();
    logic [7:0] v;
    wr(2, 8'h00);
    wr(1, 8'h12);
    rd(1, v); check("R4 live high write", v, 8'h12);
    wr(0, 8'h34);
    rd(0, v); check("R4 live low write", v, 8'h34);
    rd(1, v); check("R4 high kept on low write", v, 8'h12);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    for (int p = 0; p < 4; p++) begin
      wr(2, 8'(p << 2));
      wr(1, 8'h00);
      wr(0, 8'h00);
      wr(2, 8'((p << 2) | 1));
      repeat (39) @(negedge clk);
      wr(2, 8'(p << 2));
      rd(0, v); check($sformatf("R7 prescale %0d over 40 ticks", p), v, 8'(40 >> p));
    end
  endtask

  task automatic t_buffered();
    logic [7:0] v;
    wr(2, 8'h80);
    wr(1, 8'hAB);
    rd(1, v); check("R1 shadow write readback", v, 8'hAB);
    wr(0, 8'hCD);
    wr(1, 8'h00);
    rd(1, v); check("R1 high address shows shadow not live", v, 8'h00);
    rd(0, v); check("R3 low byte committed", v, 8'hCD);
    rd(1, v); check("R2 low read latched live high", v, 8'hAB);
    wr(2, 8'h00);
    rd(1, v); check("R3 live high from shadow, untouched by shadow write", v, 8'hAB);
    // rollover between low read and high read
    wr(2, 8'h80);
    wr(1, 8'h12);
    wr(0, 8'hFF);
    rd(0, v); check("R3 loaded low", v, 8'hFF);
    wr(2, 8'h81);
    repeat (3) @(negedge clk);
    wr(2, 8'h80);
    rd(1, v); check("R2 no tear across rollover", v, 8'h12);
    wr(2, 8'h00);
    rd(1, v); check("R5 carry into high", v, 8'h13);
    rd(0, v); check("R5 low after four ticks", v, 8'h03);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(2, 8'h00);
    wr(3, 8'h02);
    wr(1, 8'hFF);
    wr(0, 8'hFE);
    wr(2, 8'h01);
    check("R6 irq low before wrap", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R6 irq low at 0xFFFF", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R6 irq on wrap", {7'd0, irq}, 8'h01);
    wr(2, 8'h00);
    rd(0, v); check("R5 wrapped low", v, 8'h01);
    rd(1, v); check("R5 wrapped high", v, 8'h00);
    repeat (5) @(negedge clk);
    rd(3, v); check("R5 flag sticky", v, 8'h03);
    wr(3, 8'h01);
    check("R6 irq masked by enable", {7'd0, irq}, 8'h00);
    rd(3, v); check("R6 flag kept while masked", v, 8'h01);
    wr(3, 8'h03);
    check("R6 irq with both set", {7'd0, irq}, 8'h01);
    wr(3, 8'h02);
    check("R5 flag cleared by writing 0", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_trigger();
    logic [7:0] v;
    wr(1, 8'h56);
    wr(0, 8'h78);
    trig_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    trig_clr = 1'b0;
    rd(0, v); check("R9 trigger clears low", v, 8'h00);
    rd(1, v); check("R9 trigger clears high", v, 8'h00);
    rd(3, v); check("R9 trigger leaves flag clear", v, 8'h02);
    // collision: write and trigger in the same cycle
    wr(1, 8'h9A);
    trig_clr = 1'b1;
    wr(0, 8'h55);
    trig_clr = 1'b0;
    rd(0, v); check("R10 write beats trigger low", v, 8'h55);
    rd(1, v); check("R10 write beats trigger high", v, 8'h9A);
  endtask

  task automatic t_pre_clear();
    logic [7:0] v;
    wr(2, 8'h0C);
    wr(1, 8'h00);
    wr(0, 8'h00);
    wr(2, 8'h0D); repeat (4) @(negedge clk); wr(2, 8'h0C);
    wr(1, 8'h00);
    wr(2, 8'h0D); repeat (2) @(negedge clk); wr(2, 8'h0C);
    rd(0, v); check("R8 high write keeps prescaler", v, 8'h01);
    wr(0, 8'h00);
    wr(2, 8'h0D); repeat (4) @(negedge clk); wr(2, 8'h0C);
    wr(0, 8'h00);
    wr(2, 8'h0D); repeat (2) @(negedge clk); wr(2, 8'h0C);
    rd(0, v); check("R8 low write clears prescaler", v, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(2, 8'h02);
    wr(1, 8'h00);
    wr(0, 8'h00);
    wr(2, 8'h03);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(2, 8'h02);
    rd(0, v); check("R11 one tick per external edge", v, 8'h05);
    for (int k = 0; k < 3; k++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(0, v); check("R11 no count with run off", v, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_prescale();
    t_buffered();
    t_overflow();
    t_trigger();
    t_pre_clear();
    t_ext();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule